// File: doc/BRIEF.md
# Trap Capture and Interrupt-Enable Status Unit

This unit sits beside the instruction sequencer of a small 8-bit processor core. It catches a non-maskable trap request that arrives asynchronously on a pin, holds it until the sequencer acknowledges it, and keeps the global interrupt-enable flag up to date as interrupts are taken and as enable and disable operations run.

When a trap is taken, the enable flag is cleared and its old value is saved. Only the next read-mask operation returns that saved value. Every later read returns the live flag, so software can tell once whether interrupts were on before the trap. The same read-mask operation also samples a serial input bit. A set-mask operation can load a serial output latch.

The trap pin goes through a synchronizer and a rising-edge detector. The captured request is shown to the sequencer only while the pin is still high, so the request is qualified by both an edge and a level.

Top module: `trap_ie_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all of the following: the trap flip-flop, `trap_pending`, `int_enable`, the saved enable value, the first-read marker, `rdmask_ie`, `rdmask_sid` and `sod_out`.
- R2: `trap_pin` passes through SYNC_STAGES flip-flops (default 2). A rising edge then sets the trap flip-flop. When the pin goes high before clock edge k, `trap_pending` is high after edge k+SYNC_STAGES. A pin that simply stays high never re-arms the flip-flop.
- R3: `trap_pending` is high only while the trap flip-flop is set and the synchronized pin is high. When the pin drops, `trap_pending` falls SYNC_STAGES edges later, and the flip-flop stays set.
- R4: A `trap_ack` pulse clears the trap flip-flop. If a new synchronized rising edge falls in the same cycle, the flip-flop stays set.
- R5: A `trap_ack` pulse clears `int_enable` at the next edge and saves the value the flag had before it. `trap_ack` wins over `intr_ack`, `ei_op` and `di_op` in the same cycle.
- R6: The first `rdmask_stb` after a trap acknowledge reports the saved pre-trap enable value on `rdmask_ie`. Each later read reports the live `int_enable`.
- R7: An `intr_ack` pulse clears `int_enable`. A following read-mask reports 0.
- R8: `ei_op` sets `int_enable` and `di_op` clears it, with `di_op` winning over `ei_op`. Either operation cancels a pending first read, so the next read reports the live flag.
- R9: On `rdmask_stb`, `rdmask_ie` and `rdmask_sid` are loaded at that edge. `rdmask_sid` takes the value of `serial_in`. Both outputs hold between strobes.
- R10: On `setmask_stb`, `sod_out` takes `setmask_data[0]` only when `setmask_data[1]` is 1. Otherwise `sod_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_pin | input | 1 | Asynchronous trap request |
| trap_ack | input | 1 | Sequencer takes the trap |
| intr_ack | input | 1 | Sequencer takes a maskable interrupt |
| ei_op | input | 1 | Enable-interrupt operation |
| di_op | input | 1 | Disable-interrupt operation |
| rdmask_stb | input | 1 | Read-mask operation |
| setmask_stb | input | 1 | Set-mask operation |
| setmask_data | input | 2 | Bit 1 enables the serial output write; bit 0 is the new value |
| serial_in | input | 1 | Serial input bit |
| trap_pending | output | 1 | Trap request to the sequencer |
| int_enable | output | 1 | Global interrupt-enable flag |
| rdmask_ie | output | 1 | Enable bit from the last read-mask |
| rdmask_sid | output | 1 | Serial input from the last read-mask |
| sod_out | output | 1 | Serial output latch |

## Verification
The bench drives a trap edge in exactly the cycle of an acknowledge. A design that gave priority to the clear would lose that trap. The bench reads the mask twice after a trap. A design that never cleared the first-read marker would keep reporting the stale saved bit, and one that never set it would report 0 where the pre-trap value was 1. The bench drops the pin while the flip-flop is still set, and later holds the pin high across an acknowledge. A design that was only edge-qualified would keep requesting, and one that was only level-qualified would fire again. The bench also sends enable or disable after a trap, and enable together with the acknowledge, to catch a marker that is not cancelled and wrong priority among the operations.

// File: rtl/trap_ie_pkg.sv
package trap_ie_pkg;

    // set-mask data field positions
    localparam int SM_WIDTH   = 2;
    localparam int SM_VAL_BIT = 0;
    localparam int SM_WE_BIT  = 1;

    typedef struct packed {
        logic ie;
        logic sid;
    } mask_rd_t;

    typedef struct packed {
        logic trap_ack;
        logic intr_ack;
        logic ei;
        logic di;
        logic rdmask;
    } ie_ops_t;

    function automatic logic pick_read_ie(logic first, logic saved, logic live);
        return first ? saved : live;
    endfunction

endpackage

// File: rtl/trap_sync.sv
module trap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;

endmodule

// File: rtl/trap_latch.sv
module trap_latch (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic ack,
    input  logic level,
    output logic armed,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)       armed <= 1'b0;
        else if (rise) armed <= 1'b1;
        else if (ack)  armed <= 1'b0;
    end

    assign pending = armed & level;

    // R2
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> armed);

    // R4
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !rise) |=> !armed);

    // R4
    no_spont_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !rise) |=> !armed);

endmodule

// File: rtl/ie_tracker.sv
module ie_tracker
    import trap_ie_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ie_ops_t  ops,
    input  logic     sid,
    output logic     ie_flag,
    output mask_rd_t rd_word
);
    logic saved_ie;
    logic first_rd;

    always_ff @(posedge clk) begin
        if (rst)               ie_flag <= 1'b0;
        else if (ops.trap_ack) ie_flag <= 1'b0;
        else if (ops.intr_ack) ie_flag <= 1'b0;
        else if (ops.di)       ie_flag <= 1'b0;
        else if (ops.ei)       ie_flag <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_ie <= 1'b0;
            first_rd <= 1'b0;
        end else if (ops.trap_ack) begin
            saved_ie <= ie_flag;
            first_rd <= 1'b1;
        end else if (ops.rdmask || ops.ei || ops.di) begin
            first_rd <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_word <= '0;
        end else if (ops.rdmask) begin
            rd_word.ie  <= pick_read_ie(first_rd, saved_ie, ie_flag);
            rd_word.sid <= sid;
        end
    end

    // R5
    trap_saves_chk: assert property (@(posedge clk) disable iff (rst)
        ops.trap_ack |=> (!ie_flag && saved_ie == $past(ie_flag) && first_rd));

    // R7
    intr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ops.intr_ack |=> !ie_flag);

    // R8
    ei_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (ops.ei && !ops.di && !ops.trap_ack && !ops.intr_ack) |=> ie_flag);

    // R8
    cancel_first_chk: assert property (@(posedge clk) disable iff (rst)
        ((ops.ei || ops.di || ops.rdmask) && !ops.trap_ack) |=> !first_rd);

    // R6
    first_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ops.rdmask && first_rd) |=> rd_word.ie == $past(saved_ie));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ops.rdmask |=> $stable(rd_word));

endmodule

// File: rtl/trap_ie_ctrl.sv
module trap_ie_ctrl
    import trap_ie_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trap_pin,
    input  logic                trap_ack,
    input  logic                intr_ack,
    input  logic                ei_op,
    input  logic                di_op,
    input  logic                rdmask_stb,
    input  logic                setmask_stb,
    input  logic [SM_WIDTH-1:0] setmask_data,
    input  logic                serial_in,
    output logic                trap_pending,
    output logic                int_enable,
    output logic                rdmask_ie,
    output logic                rdmask_sid,
    output logic                sod_out
);
    logic     trap_lvl;
    logic     trap_rise;
    logic     trap_armed;
    ie_ops_t  ops;
    mask_rd_t rd_word;

    trap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin   (trap_pin),
        .level (trap_lvl),
        .rise  (trap_rise)
    );

    trap_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .rise    (trap_rise),
        .ack     (trap_ack),
        .level   (trap_lvl),
        .armed   (trap_armed),
        .pending (trap_pending)
    );

    always_comb begin
        ops.trap_ack = trap_ack;
        ops.intr_ack = intr_ack;
        ops.ei       = ei_op;
        ops.di       = di_op;
        ops.rdmask   = rdmask_stb;
    end

    ie_tracker u_ie (
        .clk     (clk),
        .rst     (rst),
        .ops     (ops),
        .sid     (serial_in),
        .ie_flag (int_enable),
        .rd_word (rd_word)
    );

    assign rdmask_ie  = rd_word.ie;
    assign rdmask_sid = rd_word.sid;

    always_ff @(posedge clk) begin
        if (rst)
            sod_out <= 1'b0;
        else if (setmask_stb && setmask_data[SM_WE_BIT])
            sod_out <= setmask_data[SM_VAL_BIT];
    end

    // R3
    pend_level_chk: assert property (@(posedge clk) disable iff (rst)
        trap_pending |-> (trap_lvl && trap_armed));

    // R10
    sod_load_chk: assert property (@(posedge clk) disable iff (rst)
        (setmask_stb && setmask_data[SM_WE_BIT]) |=> sod_out == $past(setmask_data[SM_VAL_BIT]));

    // R10
    sod_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(setmask_stb && setmask_data[SM_WE_BIT]) |=> $stable(sod_out));

endmodule

// File: tb/test_trap_ie_ctrl.sv
`timescale 1ns/1ps
module test_trap_ie_ctrl;
    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trap_pin = 0, trap_ack = 0, intr_ack = 0, ei_op = 0, di_op = 0;
    logic       rdmask_stb = 0, setmask_stb = 0, serial_in = 0;
    logic [1:0] setmask_data = 2'b00;
    logic       trap_pending, int_enable, rdmask_ie, rdmask_sid, sod_out;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    trap_ie_ctrl #(.SYNC_STAGES(STG)) i_trap_ie_ctrl (
        .clk(clk), .rst(rst), .trap_pin(trap_pin), .trap_ack(trap_ack),
        .intr_ack(intr_ack), .ei_op(ei_op), .di_op(di_op),
        .rdmask_stb(rdmask_stb), .setmask_stb(setmask_stb),
        .setmask_data(setmask_data), .serial_in(serial_in),
        .trap_pending(trap_pending), .int_enable(int_enable),
        .rdmask_ie(rdmask_ie), .rdmask_sid(rdmask_sid), .sod_out(sod_out)
    );

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic pulse_ack();  trap_ack = 1;  step(); trap_ack = 0;  endtask
    task automatic pulse_ei();   ei_op = 1;     step(); ei_op = 0;     endtask
    task automatic pulse_di();   di_op = 1;     step(); di_op = 0;     endtask
    task automatic pulse_rd();   rdmask_stb = 1; step(); rdmask_stb = 0; endtask

    task automatic t_reset();
        rst = 1; step(2); rst = 0;
        chk("R1", "trap_pending", trap_pending, 0);
        chk("R1", "int_enable", int_enable, 0);
        chk("R1", "rdmask_ie", rdmask_ie, 0);
        chk("R1", "rdmask_sid", rdmask_sid, 0);
        chk("R1", "sod_out", sod_out, 0);
    endtask

    task automatic t_trap_basic();
        trap_pin = 1;
        step(STG);
        chk("R2", "pending too early", trap_pending, 0);
        step();
        chk("R2", "pending after sync", trap_pending, 1);
        pulse_ack();
        chk("R4", "pending after ack", trap_pending, 0);
        step(4);
        chk("R2", "held pin no rearm", trap_pending, 0);
        trap_pin = 0; step(STG + 2);
    endtask

    task automatic t_level();
        trap_pin = 1; step(STG + 1);
        chk("R3", "pending pin high", trap_pending, 1);
        trap_pin = 0; step(STG);
        chk("R3", "pending pin low", trap_pending, 0);
        trap_pin = 1; step(STG);
        chk("R3", "armed still set", trap_pending, 1);
        pulse_ack(); trap_pin = 0; step(STG + 2);
    endtask

    task automatic t_collide();
        trap_pin = 1; step(STG);
        trap_ack = 1; step(); trap_ack = 0;
        chk("R4", "edge beats ack", trap_pending, 1);
        pulse_ack();
        chk("R4", "later ack clears", trap_pending, 0);
        trap_pin = 0; step(STG + 2);
    endtask

    task automatic t_shadow();
        pulse_ei();
        chk("R8", "ei sets", int_enable, 1);
        pulse_ack();
        chk("R5", "trap clears ie", int_enable, 0);
        pulse_rd();
        chk("R6", "first read saved", rdmask_ie, 1);
        pulse_rd();
        chk("R6", "second read live", rdmask_ie, 0);
        pulse_ack();
        pulse_rd();
        chk("R6", "first read saved 0", rdmask_ie, 0);
    endtask

    task automatic t_intr();
        pulse_ei();
        intr_ack = 1; step(); intr_ack = 0;
        chk("R7", "intr clears ie", int_enable, 0);
        pulse_rd();
        chk("R7", "read after intr", rdmask_ie, 0);
    endtask

    task automatic t_cancel();
        pulse_ei(); pulse_ack(); pulse_di();
        pulse_rd();
        chk("R8", "di cancels first", rdmask_ie, 0);
        pulse_ack(); pulse_ei();
        pulse_rd();
        chk("R8", "ei cancels first", rdmask_ie, 1);
        ei_op = 1; di_op = 1; step(); ei_op = 0; di_op = 0;
        chk("R8", "di beats ei", int_enable, 0);
    endtask

    task automatic t_prio();
        pulse_ei();
        trap_ack = 1; ei_op = 1; step(); trap_ack = 0; ei_op = 0;
        chk("R5", "ack beats ei", int_enable, 0);
        pulse_rd();
        chk("R5", "saved with ei", rdmask_ie, 1);
    endtask

    task automatic t_sid();
        serial_in = 1; pulse_rd();
        chk("R9", "sid 1", rdmask_sid, 1);
        serial_in = 0; step(2);
        chk("R9", "sid holds", rdmask_sid, 1);
        pulse_rd();
        chk("R9", "sid 0", rdmask_sid, 0);
    endtask

    task automatic t_sod();
        setmask_stb = 1; setmask_data = 2'b11; step(); setmask_stb = 0;
        chk("R10", "sod load 1", sod_out, 1);
        setmask_stb = 1; setmask_data = 2'b01; step(); setmask_stb = 0;
        chk("R10", "sod no we", sod_out, 1);
        setmask_stb = 0; setmask_data = 2'b10; step();
        chk("R10", "sod no strobe", sod_out, 1);
        setmask_stb = 1; setmask_data = 2'b10; step(); setmask_stb = 0;
        chk("R10", "sod load 0", sod_out, 0);
    endtask

    initial begin
        step();
        t_reset();
        t_trap_basic();
        t_level();
        t_collide();
        t_shadow();
        t_intr();
        t_cancel();
        t_prio();
        t_sid();
        t_sod();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule